// File: doc/BRIEF.md
# Coprocessor Issue and Handshake Unit

This unit sits in the execute stage of a host processor. It looks at the instruction that has reached execute. If that instruction is one the host cannot run itself, it decides whether to offer it to the attached coprocessors. It drives an active-low commit strobe and reads back two response lines from the coprocessors: absent and busy. From that response it does one of three things in the same cycle: it lets the pipeline move on, it holds the pipeline in a busy-wait, or it asks for the undefined-instruction trap. Host and coprocessor pipelines run in lock-step on one clock.

A busy-wait can be cut short by an interrupt. If an interrupt source that is not disabled is pending while the unit is stalled, the unit abandons the coprocessor instruction. From the next cycle it drives the commit strobe high, drops the stall and pulses a one-hot interrupt-take request. Source 0 (the fast interrupt) wins over higher indices. Instruction decode and condition evaluation happen upstream and arrive here as flags.

Top module: `cp_issue_unit`

## Requirements
- R1: `commit_n_o` is low in a cycle only when `ex_valid_i`, `ex_cp_class_i` and `cond_pass_i` are all high and the instruction has not been abandoned; otherwise it is high.
- R2: When any of `ex_valid_i`, `ex_cp_class_i` or `cond_pass_i` is low (this includes an instruction flushed by a branch), the response lines are ignored: `stall_o` and `undef_trap_o` stay low.
- R3: For an eligible instruction, the response absent=0, busy=0 leaves `stall_o` and `undef_trap_o` low in that cycle.
- R4: For an eligible instruction, the response absent=1, busy=1 raises `undef_trap_o` in that cycle.
- R5: For an eligible instruction, the invalid response absent=1, busy=0 is treated as absent and raises `undef_trap_o`.
- R6: For an eligible instruction, the response absent=0, busy=1 holds `stall_o` high in every cycle that busy stays high. `stall_o` falls in the cycle busy goes low.
- R7: If an enabled interrupt request is high during a stall cycle, then in the next cycle `commit_n_o` is high, `stall_o` is low and `int_take_o` carries a one-cycle one-hot pulse. `commit_n_o` stays high until the eligibility flags drop.
- R8: An interrupt whose disable bit in `int_dis_i` is set has no effect during a stall. An interrupt request outside a stall never produces `int_take_o`.
- R9: When several enabled requests are pending, the lowest index is taken: bit 0 is the fast interrupt and bit 1 the normal interrupt.
- R10: Out of reset `commit_n_o` is high and the other outputs are low. In every cycle, at most one of `stall_o`, `undef_trap_o` and `int_take_o` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ex_valid_i | input | 1 | Execute stage holds a live instruction |
| ex_cp_class_i | input | 1 | Instruction is in the coprocessor/undefined class |
| cond_pass_i | input | 1 | Instruction passed its condition test |
| cp_absent_i | input | 1 | Coprocessor absent response |
| cp_busy_i | input | 1 | Coprocessor busy response |
| int_req_i | input | NUM_INT | Interrupt requests, bit 0 highest priority |
| int_dis_i | input | NUM_INT | Interrupt disable bits, 1 = masked |
| commit_n_o | output | 1 | Active-low commit strobe to coprocessors |
| stall_o | output | 1 | Hold the host pipeline |
| undef_trap_o | output | 1 | Request undefined-instruction trap |
| int_take_o | output | NUM_INT | One-hot interrupt-take pulse after an abandon |

## Verification
The hardest state to reach is the abandoned instruction. It exists only after a busy-wait has started and an enabled interrupt has arrived while the eligibility flags are still held. In that state the strobe must stay high even though the instruction still looks eligible. The bench builds a stall with busy held high, then raises one request (or both, or a masked one) for a single cycle. It holds the eligibility flags across the following cycles to see the latched abandon, and finally drops and re-raises them to show that a fresh instruction commits again.

// File: rtl/cp_issue_pkg.sv
package cp_issue_pkg;
  typedef enum logic [1:0] {
    RESP_GO    = 2'd0,
    RESP_WAIT  = 2'd1,
    RESP_UNDEF = 2'd2
  } cp_resp_e;
endpackage

// File: rtl/cp_resp_decode.sv
module cp_resp_decode
  import cp_issue_pkg::*;
(
  input  logic     absent_i,
  input  logic     busy_i,
  output cp_resp_e resp_o
);
  // absent dominates: the invalid code (absent=1, busy=0) folds into UNDEF
  always_comb begin
    if (absent_i)    resp_o = RESP_UNDEF;
    else if (busy_i) resp_o = RESP_WAIT;
    else             resp_o = RESP_GO;
  end
endmodule

// File: rtl/cp_int_arb.sv
module cp_int_arb #(
  parameter int unsigned NUM_INT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] req_i,
  input  logic [NUM_INT-1:0] dis_i,
  output logic [NUM_INT-1:0] grant_o,
  output logic               any_o
);
  logic [NUM_INT-1:0] act;
  logic [NUM_INT:0]   seen;

  assign act     = req_i & ~dis_i;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_prio
    assign grant_o[i]  = act[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | act[i];
  end

  assign any_o = seen[NUM_INT];

  p_grant_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  p_grant_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act[0]) |-> grant_o[0]);
endmodule

// File: rtl/cp_issue_unit.sv
module cp_issue_unit
  import cp_issue_pkg::*;
#(
  parameter int unsigned NUM_INT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ex_valid_i,
  input  logic               ex_cp_class_i,
  input  logic               cond_pass_i,
  input  logic               cp_absent_i,
  input  logic               cp_busy_i,
  input  logic [NUM_INT-1:0] int_req_i,
  input  logic [NUM_INT-1:0] int_dis_i,
  output logic               commit_n_o,
  output logic               stall_o,
  output logic               undef_trap_o,
  output logic [NUM_INT-1:0] int_take_o
);
  cp_resp_e           resp;
  logic               eligible, live, busy_wait, int_hit, int_any;
  logic               kill_q;
  logic [NUM_INT-1:0] grant, take_q;

  cp_resp_decode u_dec (
    .absent_i (cp_absent_i),
    .busy_i   (cp_busy_i),
    .resp_o   (resp)
  );

  cp_int_arb #(.NUM_INT(NUM_INT)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (int_req_i),
    .dis_i   (int_dis_i),
    .grant_o (grant),
    .any_o   (int_any)
  );

  assign eligible  = ex_valid_i & ex_cp_class_i & cond_pass_i;
  assign live      = eligible & ~kill_q;
  assign busy_wait = live & (resp == RESP_WAIT);
  assign int_hit   = busy_wait & int_any;

  // abandon latch: holds the strobe high until the instruction leaves execute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_q <= 1'b0;
      take_q <= '0;
    end else begin
      kill_q <= kill_q ? eligible : int_hit;
      take_q <= int_hit ? grant : '0;
    end
  end

  assign commit_n_o   = ~live;
  assign stall_o      = busy_wait;
  assign undef_trap_o = live & (resp == RESP_UNDEF);
  assign int_take_o   = take_q;

  p_commit_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_n_o |-> (ex_valid_i && ex_cp_class_i && cond_pass_i));
  p_ignore_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ex_valid_i && ex_cp_class_i && cond_pass_i) |-> (!stall_o && !undef_trap_o));
  p_take_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_take_o) |=> (int_take_o == '0));
  p_take_abandons_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_take_o) |-> (commit_n_o && !stall_o));
  p_take_after_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_take_o) |-> $past(stall_o));
  p_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({stall_o, undef_trap_o, |int_take_o}) <= 1);
endmodule

// File: tb/cp_issue_unit_tb.sv
module cp_issue_unit_tb;
  localparam int NUM_INT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_valid = 0, ex_cls = 0, cond = 0, absent = 0, busy = 0;
  logic [NUM_INT-1:0] int_req = '0, int_dis = '0;
  logic commit_n, stall, trap;
  logic [NUM_INT-1:0] take;
  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  cp_issue_unit #(.NUM_INT(NUM_INT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ex_valid_i(ex_valid), .ex_cp_class_i(ex_cls),
    .cond_pass_i(cond), .cp_absent_i(absent), .cp_busy_i(busy),
    .int_req_i(int_req), .int_dis_i(int_dis), .commit_n_o(commit_n),
    .stall_o(stall), .undef_trap_o(trap), .int_take_o(take)
  );

  // {valid, class, cond, absent, busy, exp_commit_n, exp_stall, exp_trap}
  localparam logic [7:0] VEC [10] = '{
    8'b111_00_000,  // R3 go
    8'b111_11_001,  // R4 absent
    8'b111_10_001,  // R5 invalid
    8'b111_01_010,  // R6 busy
    8'b011_01_100,  // R2 flushed
    8'b011_11_100,  // R2 flushed
    8'b101_11_100,  // R2 not class
    8'b110_01_100,  // R2 cond fail
    8'b110_11_100,  // R2 cond fail
    8'b000_10_100   // R1 idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, c, p, a, b);
    ex_valid = v; ex_cls = c; cond = p; absent = a; busy = b;
  endtask

  task automatic outs(input string req, input logic cn, s, t, input logic [NUM_INT-1:0] tk);
    chk(req, {commit_n, stall, trap, take}, {cn, s, t, tk});
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    #1;
    outs("R10 in reset", 1, 0, 0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    outs("R10 after reset", 1, 0, 0, '0);

    // table walk, no interrupts: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec %0d", i),
          {commit_n, stall, trap, take}, {VEC[i][2], VEC[i][1], VEC[i][0], 2'b00});
    end

    // R6: multi-cycle busy then release
    @(negedge clk); drive(1, 1, 1, 0, 1); #1;
    outs("R6 busy c0", 0, 1, 0, '0);
    @(negedge clk); #1;
    outs("R6 busy c1", 0, 1, 0, '0);
    @(negedge clk); busy = 0; #1;
    outs("R6 release", 0, 0, 0, '0);

    // R8: interrupt without stall is ignored
    @(negedge clk); int_req = 2'b11; #1;
    outs("R8 no stall same", 0, 0, 0, '0);
    @(negedge clk); int_req = '0; #1;
    outs("R8 no stall next", 0, 0, 0, '0);

    // R8: masked interrupt during stall
    @(negedge clk); busy = 1; int_req = 2'b11; int_dis = 2'b11; #1;
    outs("R8 masked stall", 0, 1, 0, '0);
    @(negedge clk); int_req = '0; int_dis = '0; #1;
    outs("R8 masked next", 0, 1, 0, '0);

    // R7: IRQ abandons busy-wait
    @(negedge clk); int_req = 2'b10; #1;
    outs("R7 hit cycle", 0, 1, 0, '0);
    @(negedge clk); int_req = '0; #1;
    outs("R7 abandon", 1, 0, 0, 2'b10);
    @(negedge clk); #1;
    outs("R7 held high", 1, 0, 0, '0);
    @(negedge clk); absent = 1; #1;
    outs("R7 held no trap", 1, 0, 0, '0);
    @(negedge clk); drive(0, 0, 0, 0, 0); #1;
    outs("R1 drop", 1, 0, 0, '0);
    @(negedge clk); drive(1, 1, 1, 0, 0); #1;
    outs("R1 fresh commit", 0, 0, 0, '0);

    // R9: both pending, FIQ disabled -> IRQ; both enabled -> FIQ
    @(negedge clk); busy = 1; int_req = 2'b11; int_dis = 2'b01; #1;
    outs("R9 stall", 0, 1, 0, '0);
    @(negedge clk); int_req = '0; int_dis = '0; #1;
    outs("R9 masked fiq -> irq", 1, 0, 0, 2'b10);
    @(negedge clk); drive(0, 0, 0, 0, 0);
    @(negedge clk); drive(1, 1, 1, 0, 1); int_req = 2'b11; #1;
    outs("R9 stall2", 0, 1, 0, '0);
    @(negedge clk); int_req = '0; #1;
    outs("R9 fiq wins", 1, 0, 0, 2'b01);
    @(negedge clk); #1;
    outs("R10 pulse ends", 1, 0, 0, '0);

    @(negedge clk); drive(0, 0, 0, 0, 0);
    rst_n = 1'b0; #1;
    outs("R10 re-reset", 1, 0, 0, '0);
    finish_run();
  end
endmodule